// File: doc/BRIEF.md
# Multiword DMA Device-Side Handshake Controller

This block sits on the device side of a 16-bit parallel drive interface. It runs multiword DMA transfers once a command has set them up. A transfer is armed with a direction and a word count. The block raises its request line and waits, for as long as the host needs, for the host's active-low acknowledge. After that it moves one word per host strobe pulse. Read strobes take words from a show-ahead source FIFO and drive them onto the data bus. Write strobes capture the bus word and push it into a sink FIFO.

The request can be withdrawn partway through a command in two cases. The first is when the FIFO cannot keep up: the source is empty on a read, or the sink is full on a write. The second is when the host gives up the bus by negating its acknowledge. A parameter selects what happens after a host release. In one variant the request stays up and the block waits for the acknowledge to return. In the other the request is dropped for a programmable rearm gap and then raised again. In both cases the transfer resumes until the count is used up. On the last word the request is withdrawn as soon as that strobe's leading edge is seen. A one-cycle done pulse follows completion.

All host-side strobes are resynchronised to the internal clock, and every transfer is triggered on the trailing edge of a strobe. The data bus is represented by a separate input, output and output-enable so that the pad ring can place the tristate buffer.

Top module: `mwdma_dev_ctrl`

## Requirements
- R1: After reset `dma_req`, `bus_oe`, `done`, `src_pop` and `snk_push` are all 0.
- R2: A start with a nonzero length and a ready FIFO raises `dma_req`, and it stays high for any length of time while `dma_ack_n` remains 1.
- R3: In a read transfer, while `dma_ack_n` is 0, `bus_dout` equals `src_data`. Each completed pulse on `rd_strobe_n` (low, then back to 1) pops exactly one word.
- R4: In a write transfer, each completed pulse on `wr_strobe_n` pushes exactly one word into the sink. That word is the value on `bus_din` during the pulse.
- R5: These strobes move no data: a strobe of the direction not selected, any strobe while `dma_ack_n` is 1, and any strobe while either bit of `cs_n` is 0.
- R6: On the final word `dma_req` falls after the strobe's leading edge and before its trailing edge. After the trailing edge `done` is 1 for exactly one cycle, and no more words move than the programmed length.
- R7: While a transfer is active, `dma_req` is 0 whenever the source FIFO is empty (read) or the sink FIFO is full (write). It returns to 1 once a word or free space is available.
- R8: When the host negates `dma_ack_n` with words left, behaviour depends on `HOLD_REQ`. With `HOLD_REQ`=0 (the default), `dma_req` drops and is raised again after `REARM_GAP` cycles. With `HOLD_REQ`=1, it stays raised.
- R9: A start with a length of 0 produces one `done` pulse and never raises `dma_req`.
- R10: A start pulse while a transfer is in progress is ignored. The running transfer keeps its direction and its remaining count.
- R11: `bus_oe` is 1 only during an active read transfer with `dma_ack_n` at 0. It is 0 in write transfers and whenever `dma_ack_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | One-cycle pulse arming a transfer |
| xfer_dir_rd | input | 1 | 1 = read (device to host), 0 = write |
| xfer_len | input | LEN_W | Number of words in the transfer |
| dma_req | output | 1 | DMA request to the host, active high |
| dma_ack_n | input | 1 | Host DMA acknowledge, active low |
| rd_strobe_n | input | 1 | Host read strobe, active low |
| wr_strobe_n | input | 1 | Host write strobe, active low |
| cs_n | input | 2 | Host chip selects, active low; both must be 1 during DMA |
| bus_din | input | DATA_W | Data bus as received from the host |
| bus_dout | output | DATA_W | Data bus value driven toward the host |
| bus_oe | output | 1 | Output enable for the data bus pads |
| src_data | input | DATA_W | Head word of the source FIFO (show-ahead) |
| src_empty | input | 1 | Source FIFO empty |
| src_pop | output | 1 | Pop the source FIFO head |
| snk_data | output | DATA_W | Word for the sink FIFO |
| snk_full | input | 1 | Sink FIFO full |
| snk_push | output | 1 | Push `snk_data` into the sink FIFO |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
A table of vectors exercises both directions at lengths 1, 3, 4 and 6 with distinct data seeds. Length 1 separates the final-word path from the mid-burst path, and the longer runs show that words are counted and not just passed through. Directed tests then cover the following cases:
- Strobes while the host has released the bus, strobes of the wrong direction and strobes with a chip select low. Any data moved in these cases would reveal broken qualification.
- An empty source and a full sink, to tell FIFO pacing apart from release handling.
- A host release mid-command, which shows the gap before the request is raised again.
- A zero-length start and a start issued during a run, which show whether the count and direction are latched once.

// File: rtl/mwdma_pkg.sv
package mwdma_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_GAP  = 2'd2,
      ST_LAST = 2'd3
   } mw_state_e;

   localparam int unsigned LN_ACK = 0;
   localparam int unsigned LN_RD  = 1;
   localparam int unsigned LN_WR  = 2;
   localparam int unsigned LN_CS  = 3;
   localparam int unsigned LN_NUM = 4;

endpackage

// File: rtl/mwdma_sync.sv
module mwdma_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mwdma_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("mwdma_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mwdma_edge.sv
module mwdma_edge #(
   parameter int unsigned WIDTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] rise,
   output logic [WIDTH-1:0] fall
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;
endmodule

// File: rtl/mwdma_wordcnt.sv
module mwdma_wordcnt #(
   parameter int unsigned LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] load_val,
   input  logic             dec,
   output logic [LEN_W-1:0] remain,
   output logic             at_one
);
   logic [LEN_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (load)              cnt_q <= load_val;
      else if (dec && cnt_q != 0) cnt_q <= cnt_q - LEN_W'(1);
   end

   assign remain = cnt_q;
   assign at_one = (cnt_q == LEN_W'(1));
endmodule

// File: rtl/mwdma_dev_ctrl.sv
module mwdma_dev_ctrl
   import mwdma_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned LEN_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          HOLD_REQ    = 1'b0,
   parameter int unsigned REARM_GAP   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_start,
   input  logic              xfer_dir_rd,
   input  logic [LEN_W-1:0]  xfer_len,
   output logic              dma_req,
   input  logic              dma_ack_n,
   input  logic              rd_strobe_n,
   input  logic              wr_strobe_n,
   input  logic [1:0]        cs_n,
   input  logic [DATA_W-1:0] bus_din,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_oe,
   input  logic [DATA_W-1:0] src_data,
   input  logic              src_empty,
   output logic              src_pop,
   output logic [DATA_W-1:0] snk_data,
   input  logic              snk_full,
   output logic              snk_push,
   output logic              done
);
   localparam int unsigned GAP_W = $clog2(REARM_GAP + 1) < 1 ? 1 : $clog2(REARM_GAP + 1);

   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("mwdma_dev_ctrl: DATA_W must be at least 1");
      end
      if (LEN_W < 1) begin : g_bad_len_w
         $error("mwdma_dev_ctrl: LEN_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("mwdma_dev_ctrl: SYNC_STAGES must be at least 2");
      end
      if (!HOLD_REQ && REARM_GAP < 1) begin : g_bad_gap
         $error("mwdma_dev_ctrl: REARM_GAP must be at least 1 when the request drops");
      end
   endgenerate

   // host pins turned active-high, then resynchronised
   logic [LN_NUM-1:0] pin_act;
   logic [LN_NUM-1:0] act_s;

   assign pin_act[LN_ACK] = ~dma_ack_n;
   assign pin_act[LN_RD]  = ~rd_strobe_n;
   assign pin_act[LN_WR]  = ~wr_strobe_n;
   assign pin_act[LN_CS]  = ~&cs_n;

   mwdma_sync #(.WIDTH(LN_NUM), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_act),
      .q     (act_s)
   );

   logic [2:0] e_lvl, e_rise, e_fall;
   assign e_lvl = {act_s[LN_ACK], act_s[LN_WR], act_s[LN_RD]};

   mwdma_edge #(.WIDTH(3)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (e_lvl),
      .rise  (e_rise),
      .fall  (e_fall)
   );

   logic unused_ack_rise;
   assign unused_ack_rise = e_rise[2];

   mw_state_e st_q;
   logic      dir_rd_q;
   logic      done_q, pop_q, push_q;
   logic [DATA_W-1:0] wr_hold_q, push_data_q;

   logic       in_xfer, ack_on, cs_ok, qual;
   logic       lead_evt, trail_evt, xfer_evt, last_go, rel_go, gap_end;
   logic       path_ready, cnt_load, at_one;
   logic [LEN_W-1:0] remain;

   assign in_xfer    = (st_q == ST_RUN) || (st_q == ST_LAST);
   assign ack_on     = act_s[LN_ACK];
   assign cs_ok      = ~act_s[LN_CS];
   assign qual       = in_xfer & ack_on & cs_ok;
   assign lead_evt   = dir_rd_q ? e_rise[0] : e_rise[1];
   assign trail_evt  = dir_rd_q ? e_fall[0] : e_fall[1];
   assign xfer_evt   = qual & trail_evt;
   assign last_go    = (st_q == ST_RUN) & qual & lead_evt & at_one;
   assign path_ready = dir_rd_q ? ~src_empty : ~snk_full;
   assign cnt_load   = (st_q == ST_IDLE) & xfer_start & (xfer_len != '0);

   mwdma_wordcnt #(.LEN_W(LEN_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (xfer_len),
      .dec      (xfer_evt),
      .remain   (remain),
      .at_one   (at_one)
   );

   logic unused_remain;
   assign unused_remain = ^remain;

   // release handling variant
   generate
      if (HOLD_REQ) begin : g_hold
         logic unused_ack_fall;
         assign unused_ack_fall = e_fall[2];
         assign rel_go  = 1'b0;
         assign gap_end = 1'b1;
      end else begin : g_drop
         logic [GAP_W-1:0] gap_q;
         assign rel_go = (st_q == ST_RUN) & e_fall[2];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           gap_q <= '0;
            else if (rel_go)                      gap_q <= GAP_W'(REARM_GAP);
            else if (st_q == ST_GAP && gap_q != 0) gap_q <= gap_q - GAP_W'(1);
         end
         assign gap_end = (gap_q == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         dir_rd_q <= 1'b0;
         done_q   <= 1'b0;
         pop_q    <= 1'b0;
         push_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         pop_q  <= xfer_evt & dir_rd_q;
         push_q <= xfer_evt & ~dir_rd_q;
         unique case (st_q)
            ST_IDLE: begin
               if (xfer_start) begin
                  if (xfer_len == '0) begin
                     done_q <= 1'b1;
                  end else begin
                     dir_rd_q <= xfer_dir_rd;
                     st_q     <= ST_RUN;
                  end
               end
            end
            ST_RUN: begin
               if (last_go)     st_q <= ST_LAST;
               else if (rel_go) st_q <= ST_GAP;
            end
            ST_GAP: begin
               if (gap_end) st_q <= ST_RUN;
            end
            ST_LAST: begin
               if (xfer_evt) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // write data: hold the bus word while the synchronised strobe is active
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_hold_q   <= '0;
         push_data_q <= '0;
      end else begin
         if (act_s[LN_WR])            wr_hold_q   <= bus_din;
         if (xfer_evt && !dir_rd_q)   push_data_q <= wr_hold_q;
      end
   end

   logic busy;
   assign busy = (st_q != ST_IDLE);

   assign dma_req  = (st_q == ST_RUN) & path_ready;
   assign bus_oe   = in_xfer & dir_rd_q & ~dma_ack_n;
   assign bus_dout = src_data;
   assign src_pop  = pop_q;
   assign snk_push = push_q;
   assign snk_data = push_data_q;
   assign done     = done_q;
endmodule

// File: rtl/mwdma_dev_chk.sv
module mwdma_dev_chk #(
   parameter int unsigned LEN_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             xfer_start,
   input logic [LEN_W-1:0] xfer_len,
   input logic             busy,
   input logic             dma_req,
   input logic             bus_oe,
   input logic             src_pop,
   input logic             snk_push,
   input logic             done
);
   logic [LEN_W-1:0] xlen_q, xcnt_q;
   logic             move;
   assign move = src_pop | snk_push;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xlen_q <= '0;
         xcnt_q <= '0;
      end else if (xfer_start && !busy) begin
         xlen_q <= xfer_len;
         xcnt_q <= '0;
      end else if (move) begin
         xcnt_q <= xcnt_q + LEN_W'(1);
      end
   end

   // R3 / R4: a strobe moves one word in one direction only
   p_one_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({src_pop, snk_push}));

   // R11: the bus is only driven in read transfers
   p_oe_no_push_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> !snk_push);

   // R6: done lasts a single cycle
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6: request is down when done pulses
   p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !dma_req);

   // R6 / R10: never more words than the latched length
   p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      move |-> (xcnt_q < xlen_q));
endmodule

bind mwdma_dev_ctrl mwdma_dev_chk #(.LEN_W(LEN_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .xfer_start (xfer_start),
   .xfer_len   (xfer_len),
   .busy       (busy),
   .dma_req    (dma_req),
   .bus_oe     (bus_oe),
   .src_pop    (src_pop),
   .snk_push   (snk_push),
   .done       (done)
);

// File: tb/mwdma_dev_ctrl_bench.sv
`timescale 1ns/1ps
module mwdma_dev_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xfer_start = 1'b0;
   logic        xfer_dir_rd = 1'b0;
   logic [15:0] xfer_len = '0;
   logic        dma_req;
   logic        dma_ack_n = 1'b1;
   logic        rd_strobe_n = 1'b1;
   logic        wr_strobe_n = 1'b1;
   logic [1:0]  cs_n = 2'b11;
   logic [15:0] bus_din = '0;
   logic [15:0] bus_dout;
   logic        bus_oe;
   logic [15:0] src_data;
   logic        src_empty;
   logic        src_pop;
   logic [15:0] snk_data;
   logic        snk_full = 1'b0;
   logic        snk_push;
   logic        done;

   always #2 clk = ~clk;

   mwdma_dev_ctrl u_mwdma_dev_ctrl (
      .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_dir_rd(xfer_dir_rd),
      .xfer_len(xfer_len), .dma_req(dma_req), .dma_ack_n(dma_ack_n),
      .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n), .cs_n(cs_n),
      .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
      .src_data(src_data), .src_empty(src_empty), .src_pop(src_pop),
      .snk_data(snk_data), .snk_full(snk_full), .snk_push(snk_push), .done(done)
   );

   // FIFO models and monitors
   logic [15:0] src_mem [64];
   int          src_wr = 0;
   int          src_rd = 0;
   logic [15:0] snk_mem [64];
   int          snk_cnt = 0;
   int          done_cnt = 0;
   int          req_cyc = 0;

   assign src_empty = (src_rd == src_wr);
   assign src_data  = src_mem[src_rd[5:0]];

   always @(posedge clk) begin
      if (src_pop) src_rd <= src_rd + 1;
      if (snk_push) begin
         snk_mem[snk_cnt[5:0]] <= snk_data;
         snk_cnt <= snk_cnt + 1;
      end
      if (done)    done_cnt <= done_cnt + 1;
      if (dma_req) req_cyc  <= req_cyc + 1;
   end

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load_src(input logic [15:0] seed, input int n);
      for (int i = 0; i < n; i++) begin
         src_mem[src_wr[5:0]] = seed + 16'(i);
         src_wr = src_wr + 1;
      end
   endtask

   task automatic start(input logic dir, input logic [15:0] len);
      xfer_dir_rd = dir;
      xfer_len    = len;
      xfer_start  = 1'b1;
      tick(1);
      xfer_start  = 1'b0;
   endtask

   task automatic wait_req(input string req);
      int k;
      k = 0;
      while (dma_req !== 1'b1 && k < 500) begin
         tick(1);
         k++;
      end
      chk(req, 32'(dma_req), 32'd1);
   endtask

   // one host strobe cycle; last selects the final-word checks
   task automatic word(input logic dir, input logic [15:0] val, input logic last);
      if (dir) begin
         rd_strobe_n = 1'b0;
         tick(4);
         chk("R3 bus_dout", 32'(bus_dout), 32'(val));
         chk("R11 bus_oe read", 32'(bus_oe), 32'd1);
         chk(last ? "R6 req low on last" : "R2 req held", 32'(dma_req), last ? 32'd0 : 32'd1);
         rd_strobe_n = 1'b1;
         tick(4);
      end else begin
         bus_din = val;
         tick(1);
         wr_strobe_n = 1'b0;
         tick(4);
         chk("R11 bus_oe write", 32'(bus_oe), 32'd0);
         chk(last ? "R6 req low on last" : "R2 req held", 32'(dma_req), last ? 32'd0 : 32'd1);
         wr_strobe_n = 1'b1;
         tick(4);
      end
   endtask

   // vector: {dir, len[7:0], seed[15:0], expected last word[15:0]}
   localparam logic [40:0] VECS [5] = '{
      {1'b1, 8'd3, 16'h1000, 16'h1002},
      {1'b0, 8'd4, 16'hA5A0, 16'hA5A3},
      {1'b1, 8'd1, 16'h7FFE, 16'h7FFE},
      {1'b0, 8'd1, 16'h0001, 16'h0001},
      {1'b1, 8'd6, 16'hFFF0, 16'hFFF5}
   };

   initial begin : watchdog
      #(4 * 150000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin : main
      int d0, s0, p0, r0;
      tick(3);
      rst_n = 1'b1;
      tick(2);
      // R1 reset state
      chk("R1 dma_req", 32'(dma_req), 32'd0);
      chk("R1 bus_oe", 32'(bus_oe), 32'd0);
      chk("R1 done", 32'(done), 32'd0);
      chk("R1 pop/push", 32'({src_pop, snk_push}), 32'd0);

      // table-driven transfers
      for (int v = 0; v < 5; v++) begin
         logic        dir;
         logic [7:0]  len;
         logic [15:0] seed, lastw;
         {dir, len, seed, lastw} = VECS[v];
         d0 = done_cnt; s0 = snk_cnt; p0 = src_rd;
         if (dir) load_src(seed, int'(len));
         start(dir, 16'(len));
         wait_req("R2 req raised");
         dma_ack_n = 1'b0;
         tick(2);
         for (int i = 0; i < int'(len); i++)
            word(dir, seed + 16'(i), (i == int'(len) - 1));
         dma_ack_n = 1'b1;
         tick(4);
         chk("R6 done once", 32'(done_cnt - d0), 32'd1);
         chk("R6 req idle", 32'(dma_req), 32'd0);
         if (dir) begin
            chk("R3 pops", 32'(src_rd - p0), 32'(len));
            chk("R3 last word", 32'(src_mem[6'(src_rd - 1)]), 32'(lastw));
         end else begin
            chk("R4 pushes", 32'(snk_cnt - s0), 32'(len));
            for (int i = 0; i < int'(len); i++)
               chk("R4 data", 32'(snk_mem[6'(s0 + i)]), 32'(seed + 16'(i)));
            chk("R4 last word", 32'(snk_mem[6'(snk_cnt - 1)]), 32'(lastw));
         end
      end

      // R5 / R11: ignored strobes
      load_src(16'h3300, 2);
      d0 = done_cnt; p0 = src_rd; s0 = snk_cnt;
      start(1'b1, 16'd2);
      wait_req("R2 req raised");
      rd_strobe_n = 1'b0; tick(4);
      chk("R11 bus_oe without ack", 32'(bus_oe), 32'd0);
      rd_strobe_n = 1'b1; tick(5);
      chk("R5 no pop without ack", 32'(src_rd - p0), 32'd0);
      dma_ack_n = 1'b0; tick(4);
      wr_strobe_n = 1'b0; tick(4); wr_strobe_n = 1'b1; tick(5);
      chk("R5 wrong dir pop", 32'(src_rd - p0), 32'd0);
      chk("R5 wrong dir push", 32'(snk_cnt - s0), 32'd0);
      cs_n = 2'b10; tick(3);
      rd_strobe_n = 1'b0; tick(4); rd_strobe_n = 1'b1; tick(5);
      chk("R5 cs low pop", 32'(src_rd - p0), 32'd0);
      cs_n = 2'b11; tick(3);
      word(1'b1, 16'h3300, 1'b0);
      word(1'b1, 16'h3301, 1'b1);
      dma_ack_n = 1'b1; tick(4);
      chk("R5 run completes", 32'(done_cnt - d0), 32'd1);

      // R7 read pacing on empty source
      load_src(16'h4400, 1);
      d0 = done_cnt;
      start(1'b1, 16'd3);
      wait_req("R2 req raised");
      dma_ack_n = 1'b0; tick(2);
      word(1'b1, 16'h4400, 1'b0);
      chk("R7 req low on empty", 32'(dma_req), 32'd0);
      dma_ack_n = 1'b1; tick(4);
      load_src(16'h4401, 2);
      tick(20);
      chk("R7 req back on data", 32'(dma_req), 32'd1);
      dma_ack_n = 1'b0; tick(2);
      word(1'b1, 16'h4401, 1'b0);
      word(1'b1, 16'h4402, 1'b1);
      dma_ack_n = 1'b1; tick(4);
      chk("R7 read done", 32'(done_cnt - d0), 32'd1);

      // R7 write pacing on full sink
      d0 = done_cnt;
      start(1'b0, 16'd2);
      wait_req("R2 req raised");
      dma_ack_n = 1'b0;
      snk_full = 1'b1; tick(2);
      chk("R7 req low on full", 32'(dma_req), 32'd0);
      snk_full = 1'b0; tick(2);
      chk("R7 req back on space", 32'(dma_req), 32'd1);
      word(1'b0, 16'h5500, 1'b0);
      word(1'b0, 16'h5501, 1'b1);
      dma_ack_n = 1'b1; tick(4);
      chk("R7 write done", 32'(done_cnt - d0), 32'd1);
      chk("R7 write data", 32'(snk_mem[6'(snk_cnt - 1)]), 32'h5501);

      // R8 host release mid-command (default: drop then rearm)
      load_src(16'h6600, 2);
      d0 = done_cnt;
      start(1'b1, 16'd2);
      wait_req("R2 req raised");
      dma_ack_n = 1'b0; tick(2);
      word(1'b1, 16'h6600, 1'b0);
      dma_ack_n = 1'b1;
      tick(4);
      chk("R8 req drops on release", 32'(dma_req), 32'd0);
      tick(20);
      chk("R8 req rearmed", 32'(dma_req), 32'd1);
      dma_ack_n = 1'b0; tick(2);
      word(1'b1, 16'h6601, 1'b1);
      dma_ack_n = 1'b1; tick(4);
      chk("R8 resumed to done", 32'(done_cnt - d0), 32'd1);

      // R9 zero length
      d0 = done_cnt; r0 = req_cyc;
      start(1'b1, 16'd0);
      tick(4);
      chk("R9 done on zero", 32'(done_cnt - d0), 32'd1);
      chk("R9 no request", 32'(req_cyc - r0), 32'd0);

      // R2 unbounded wait and R10 start while busy
      load_src(16'h7700, 2);
      d0 = done_cnt; p0 = src_rd; s0 = snk_cnt;
      start(1'b1, 16'd2);
      wait_req("R2 req raised");
      tick(300);
      chk("R2 req after long wait", 32'(dma_req), 32'd1);
      start(1'b0, 16'd5);
      dma_ack_n = 1'b0; tick(2);
      word(1'b1, 16'h7700, 1'b0);
      word(1'b1, 16'h7701, 1'b1);
      dma_ack_n = 1'b1; tick(4);
      chk("R10 done after original length", 32'(done_cnt - d0), 32'd1);
      chk("R10 pops", 32'(src_rd - p0), 32'd2);
      chk("R10 no pushes", 32'(snk_cnt - s0), 32'd0);
      chk("R10 idle after", 32'(dma_req), 32'd0);

      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule